// File: doc/BRIEF.md
# Speculative Store Buffer with Load Forwarding

This block keeps stores that have been decoded but not yet retired. A store takes a slot at decode time, in program order, and receives a pointer that names the slot and carries one wrap bit. Address and data come later on two independent write ports and may arrive in either order. The store can commit once it is the oldest uncommitted entry and both halves are present. Committing clears its speculative flag. After that, a drain stage hands the entry to the cache write port, one entry per handshake. An abort frees every uncommitted entry in one cycle and rewinds allocation to the oldest freed slot. Committed entries are not touched by an abort and keep draining.

A load presents its address and the allocation pointer it saw at its own decode. The block searches only the stores older than that load, from the oldest entry up to the load's pointer. If the youngest of those stores with a matching known address also has its data, the block returns that data with a hit flag. The forwarded value takes priority over anything the cache holds. If that youngest match is still waiting for its data, the block raises a wait flag instead.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `alloc_ready_o`=1, `alloc_ptr_o`=0, `commit_ready_o`=0 and `cache_wr_valid_o`=0. `alloc_ready_o` is low while DEPTH entries are occupied or while `abort_i` is high. Each accepted allocation advances `alloc_ptr_o` by one.
- R2: A store-address write fills slot `sta_slot_i` and a store-data write fills slot `std_slot_i`, in either order. Each write takes effect only when that slot holds an uncommitted entry and `abort_i` is low; otherwise it is ignored.
- R3: `commit_ready_o` is high only when `abort_i` is low, an uncommitted entry exists, and the oldest uncommitted entry holds both its address and its data. An accepted commit moves to the next entry in program order.
- R4: `cache_wr_valid_o` is high while the oldest occupied entry is committed, and `cache_wr_addr_o`/`cache_wr_data_o` then show that entry's address and data. They stay stable while `cache_wr_ready_i` is low. Each handshake frees exactly that one entry.
- R5: `abort_i` frees all uncommitted entries. In the next cycle `alloc_ptr_o` equals the pointer of the oldest freed entry, and committed entries still drain unchanged.
- R6: With `ld_valid_i` high, `ld_hit_o` is high and `ld_data_o` gives the data of the youngest matching store older than the load, provided that store holds its data. Otherwise `ld_data_o` is 0.
- R7: A store is older than a load when its position counted from the oldest entry is less than `ld_ptr_i` minus the oldest pointer, modulo 2*DEPTH. Stores at or after `ld_ptr_i` never match.
- R8: `ld_wait_o` is high, and `ld_hit_o` low, when the youngest older store with a matching address has no data yet. Entries whose address is not yet known never match.
- R9: Pointers are `$clog2(DEPTH)+1` bits wide. The low bits give the slot and the top bit toggles on each wrap, so full and empty, and the age order, stay correct across wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Decode requests a slot |
| alloc_ready_o | output | 1 | A slot can be taken this cycle |
| alloc_ptr_o | output | PTR_W | Pointer given to the allocating store |
| sta_valid_i | input | 1 | Store-address write |
| sta_slot_i | input | IDX_W | Slot targeted by the address write |
| sta_addr_i | input | ADDR_W | Store address |
| std_valid_i | input | 1 | Store-data write |
| std_slot_i | input | IDX_W | Slot targeted by the data write |
| std_data_i | input | DATA_W | Store data |
| commit_valid_i | input | 1 | Retire the oldest uncommitted store |
| commit_ready_o | output | 1 | The oldest uncommitted store can retire |
| abort_i | input | 1 | Squash all uncommitted stores |
| cache_wr_valid_o | output | 1 | Committed store offered to the cache |
| cache_wr_ready_i | input | 1 | Cache accepts the write |
| cache_wr_addr_o | output | ADDR_W | Write address |
| cache_wr_data_o | output | DATA_W | Write data |
| ld_valid_i | input | 1 | Load lookup request |
| ld_addr_i | input | ADDR_W | Load address |
| ld_ptr_i | input | PTR_W | Allocation pointer seen at the load's decode |
| ld_hit_o | output | 1 | Forwarded data valid |
| ld_wait_o | output | 1 | Matching older store has no data yet |
| ld_data_o | output | DATA_W | Forwarded data |

## Verification
The bench places several stores to one address in a row and probes them with load pointers on both sides of each store. A design that picked the oldest match, or that also searched stores younger than the load, would return the wrong data. It also runs loads against a youngest match whose data is missing; there a design that skipped ahead to an older store with data would forward a stale value. Long random runs wrap the pointers many times, with frequent cache stalls and aborts mixed with commits. These catch a full/empty mix-up at wrap, an abort that removes committed entries or rewinds to the wrong slot, and a drain whose address or data changes while the cache is stalled.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef struct packed {
    logic valid;
    logic spec;
    logic addr_ok;
    logic data_ok;
  } ssb_flags_t;
endpackage

// File: rtl/ssb_ptr_ctl.sv
module ssb_ptr_ctl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_valid_i,
  input  logic                commit_valid_i,
  input  logic                abort_i,
  input  logic                cache_wr_ready_i,
  input  ssb_pkg::ssb_flags_t cmt_flags_i,
  output logic [PTR_W-1:0]    head_o,
  output logic [PTR_W-1:0]    cmt_o,
  output logic [PTR_W-1:0]    tail_o,
  output logic                alloc_ready_o,
  output logic                alloc_fire_o,
  output logic                commit_ready_o,
  output logic                commit_fire_o,
  output logic                drain_valid_o,
  output logic                drain_fire_o
);
  logic [PTR_W-1:0] head_q, cmt_q, tail_q, occ;
  logic             full;

  assign occ  = tail_q - head_q;
  assign full = (occ == PTR_W'(DEPTH));

  assign alloc_ready_o  = !full && !abort_i;
  assign alloc_fire_o   = alloc_valid_i && alloc_ready_o;
  assign commit_ready_o = !abort_i && (cmt_q != tail_q) &&
                          cmt_flags_i.addr_ok && cmt_flags_i.data_ok;
  assign commit_fire_o  = commit_valid_i && commit_ready_o;
  assign drain_valid_o  = (head_q != cmt_q);
  assign drain_fire_o   = drain_valid_o && cache_wr_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      cmt_q  <= '0;
      tail_q <= '0;
    end else begin
      if (drain_fire_o)  head_q <= head_q + 1'b1;
      if (commit_fire_o) cmt_q  <= cmt_q + 1'b1;
      if (abort_i)           tail_q <= cmt_q;
      else if (alloc_fire_o) tail_q <= tail_q + 1'b1;
    end
  end

  assign head_o = head_q;
  assign cmt_o  = cmt_q;
  assign tail_o = tail_q;

  AST_OCC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tail_q - head_q) <= PTR_W'(DEPTH)); // R1
  AST_ALLOC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire_o |=> tail_q == $past(tail_q) + 1'b1); // R9
  AST_CMT_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_q - head_q) <= (tail_q - head_q)); // R3
  AST_ABORT_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (tail_q == cmt_q) && $stable(head_q) || $past(drain_fire_o)); // R5
endmodule

// File: rtl/ssb_slot_array.sv
module ssb_slot_array #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                alloc_en_i,
  input  logic [IDX_W-1:0]                    alloc_slot_i,
  input  logic                                sta_valid_i,
  input  logic [IDX_W-1:0]                    sta_slot_i,
  input  logic [ADDR_W-1:0]                   sta_addr_i,
  input  logic                                std_valid_i,
  input  logic [IDX_W-1:0]                    std_slot_i,
  input  logic [DATA_W-1:0]                   std_data_i,
  input  logic                                commit_en_i,
  input  logic [IDX_W-1:0]                    commit_slot_i,
  input  logic                                abort_i,
  input  logic                                drain_en_i,
  input  logic [IDX_W-1:0]                    drain_slot_i,
  output ssb_pkg::ssb_flags_t [DEPTH-1:0]     flags_o,
  output logic [DEPTH-1:0][ADDR_W-1:0]        addr_o,
  output logic [DEPTH-1:0][DATA_W-1:0]        data_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    localparam logic [IDX_W-1:0] SLOT = IDX_W'(g);
    ssb_pkg::ssb_flags_t fl_q, fl_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   data_q;
    logic                open, sta_hit, std_hit;

    assign open    = fl_q.valid && fl_q.spec && !abort_i;
    assign sta_hit = sta_valid_i && (sta_slot_i == SLOT) && open;
    assign std_hit = std_valid_i && (std_slot_i == SLOT) && open;

    always_comb begin
      fl_d = fl_q;
      if (drain_en_i && drain_slot_i == SLOT)   fl_d.valid = 1'b0;
      if (commit_en_i && commit_slot_i == SLOT) fl_d.spec  = 1'b0;
      if (sta_hit) fl_d.addr_ok = 1'b1;
      if (std_hit) fl_d.data_ok = 1'b1;
      if (abort_i && fl_q.spec) begin
        fl_d.valid = 1'b0;
        fl_d.spec  = 1'b0;
      end
      if (alloc_en_i && alloc_slot_i == SLOT)
        fl_d = '{valid: 1'b1, spec: 1'b1, addr_ok: 1'b0, data_ok: 1'b0};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fl_q   <= '0;
        addr_q <= '0;
        data_q <= '0;
      end else begin
        fl_q <= fl_d;
        if (sta_hit) addr_q <= sta_addr_i;
        if (std_hit) data_q <= std_data_i;
      end
    end

    assign flags_o[g] = fl_q;
    assign addr_o[g]  = addr_q;
    assign data_o[g]  = data_q;

    AST_DRAIN_COMMITTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (drain_en_i && drain_slot_i == SLOT) |-> (fl_q.valid && !fl_q.spec)); // R4
    AST_COMMIT_COMPLETE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (commit_en_i && commit_slot_i == SLOT) |-> (fl_q.valid && fl_q.spec)); // R3
  end
endmodule

// File: rtl/ssb_fwd_sel.sv
module ssb_fwd_sel #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic [PTR_W-1:0]                head_i,
  input  logic                            ld_valid_i,
  input  logic [ADDR_W-1:0]               ld_addr_i,
  input  logic [PTR_W-1:0]                ld_ptr_i,
  input  ssb_pkg::ssb_flags_t [DEPTH-1:0] flags_i,
  input  logic [DEPTH-1:0][ADDR_W-1:0]    addr_i,
  input  logic [DEPTH-1:0][DATA_W-1:0]    data_i,
  output logic                            ld_hit_o,
  output logic                            ld_wait_o,
  output logic [DATA_W-1:0]               ld_data_o
);
  logic [DEPTH-1:0] match;
  logic [PTR_W-1:0] older_cnt;
  logic [IDX_W-1:0] sel;
  logic             found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = flags_i[g].valid && flags_i[g].addr_ok && (addr_i[g] == ld_addr_i);
  end

  assign older_cnt = ld_ptr_i - head_i;

  // walk oldest to youngest; the last older match wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [IDX_W-1:0] s;
      s = head_i[IDX_W-1:0] + IDX_W'(k);
      if ((PTR_W'(k) < older_cnt) && match[s]) begin
        found = 1'b1;
        sel   = s;
      end
    end
  end

  assign ld_hit_o  = ld_valid_i && found && flags_i[sel].data_ok;
  assign ld_wait_o = ld_valid_i && found && !flags_i[sel].data_ok;
  assign ld_data_o = ld_hit_o ? data_i[sel] : '0;
endmodule

// File: rtl/spec_store_buffer.sv
module spec_store_buffer #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  output logic [PTR_W-1:0]  alloc_ptr_o,
  input  logic              sta_valid_i,
  input  logic [IDX_W-1:0]  sta_slot_i,
  input  logic [ADDR_W-1:0] sta_addr_i,
  input  logic              std_valid_i,
  input  logic [IDX_W-1:0]  std_slot_i,
  input  logic [DATA_W-1:0] std_data_i,
  input  logic              commit_valid_i,
  output logic              commit_ready_o,
  input  logic              abort_i,
  output logic              cache_wr_valid_o,
  input  logic              cache_wr_ready_i,
  output logic [ADDR_W-1:0] cache_wr_addr_o,
  output logic [DATA_W-1:0] cache_wr_data_o,
  input  logic              ld_valid_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [PTR_W-1:0]  ld_ptr_i,
  output logic              ld_hit_o,
  output logic              ld_wait_o,
  output logic [DATA_W-1:0] ld_data_o
);
  ssb_pkg::ssb_flags_t [DEPTH-1:0] flags;
  logic [DEPTH-1:0][ADDR_W-1:0]    addrs;
  logic [DEPTH-1:0][DATA_W-1:0]    datas;
  logic [PTR_W-1:0]                head, cmt, tail;
  logic                            alloc_fire, commit_fire, drain_fire;

  ssb_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .alloc_valid_i    (alloc_valid_i),
    .commit_valid_i   (commit_valid_i),
    .abort_i          (abort_i),
    .cache_wr_ready_i (cache_wr_ready_i),
    .cmt_flags_i      (flags[cmt[IDX_W-1:0]]),
    .head_o           (head),
    .cmt_o            (cmt),
    .tail_o           (tail),
    .alloc_ready_o    (alloc_ready_o),
    .alloc_fire_o     (alloc_fire),
    .commit_ready_o   (commit_ready_o),
    .commit_fire_o    (commit_fire),
    .drain_valid_o    (cache_wr_valid_o),
    .drain_fire_o     (drain_fire)
  );

  ssb_slot_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slots (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .alloc_en_i    (alloc_fire),
    .alloc_slot_i  (tail[IDX_W-1:0]),
    .sta_valid_i   (sta_valid_i),
    .sta_slot_i    (sta_slot_i),
    .sta_addr_i    (sta_addr_i),
    .std_valid_i   (std_valid_i),
    .std_slot_i    (std_slot_i),
    .std_data_i    (std_data_i),
    .commit_en_i   (commit_fire),
    .commit_slot_i (cmt[IDX_W-1:0]),
    .abort_i       (abort_i),
    .drain_en_i    (drain_fire),
    .drain_slot_i  (head[IDX_W-1:0]),
    .flags_o       (flags),
    .addr_o        (addrs),
    .data_o        (datas)
  );

  ssb_fwd_sel #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fwd (
    .head_i     (head),
    .ld_valid_i (ld_valid_i),
    .ld_addr_i  (ld_addr_i),
    .ld_ptr_i   (ld_ptr_i),
    .flags_i    (flags),
    .addr_i     (addrs),
    .data_i     (datas),
    .ld_hit_o   (ld_hit_o),
    .ld_wait_o  (ld_wait_o),
    .ld_data_o  (ld_data_o)
  );

  assign alloc_ptr_o     = tail;
  assign cache_wr_addr_o = addrs[head[IDX_W-1:0]];
  assign cache_wr_data_o = datas[head[IDX_W-1:0]];

  AST_DRAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cache_wr_valid_o && !cache_wr_ready_i) |=>
      (cache_wr_valid_o && $stable(cache_wr_addr_o) && $stable(cache_wr_data_o))); // R4
  AST_FWD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_hit_o && ld_wait_o)); // R8
endmodule

// File: tb/spec_store_buffer_bench.sv
module spec_store_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 8;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int IW = $clog2(D);
  localparam int PW = IW + 1;
  localparam int P2 = 2 * D;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          alloc_valid_i = 0, sta_valid_i = 0, std_valid_i = 0;
  logic          commit_valid_i = 0, abort_i = 0, cache_wr_ready_i = 0, ld_valid_i = 0;
  logic [IW-1:0] sta_slot_i = '0, std_slot_i = '0;
  logic [AW-1:0] sta_addr_i = '0, ld_addr_i = '0;
  logic [DW-1:0] std_data_i = '0;
  logic [PW-1:0] ld_ptr_i = '0;
  logic          alloc_ready_o, commit_ready_o, cache_wr_valid_o, ld_hit_o, ld_wait_o;
  logic [PW-1:0] alloc_ptr_o;
  logic [AW-1:0] cache_wr_addr_o;
  logic [DW-1:0] cache_wr_data_o, ld_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_store_buffer #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW)) u_spec_store_buffer (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o), .alloc_ptr_o(alloc_ptr_o),
    .sta_valid_i(sta_valid_i), .sta_slot_i(sta_slot_i), .sta_addr_i(sta_addr_i),
    .std_valid_i(std_valid_i), .std_slot_i(std_slot_i), .std_data_i(std_data_i),
    .commit_valid_i(commit_valid_i), .commit_ready_o(commit_ready_o), .abort_i(abort_i),
    .cache_wr_valid_o(cache_wr_valid_o), .cache_wr_ready_i(cache_wr_ready_i),
    .cache_wr_addr_o(cache_wr_addr_o), .cache_wr_data_o(cache_wr_data_o),
    .ld_valid_i(ld_valid_i), .ld_addr_i(ld_addr_i), .ld_ptr_i(ld_ptr_i),
    .ld_hit_o(ld_hit_o), .ld_wait_o(ld_wait_o), .ld_data_o(ld_data_o)
  );

  // reference model: monotonic counters, slot contents
  int          m_head, m_cmt, m_tail;
  bit          m_aok [D];
  bit          m_dok [D];
  logic [AW-1:0] m_addr [D];
  logic [DW-1:0] m_data [D];
  int          n_cmp = 0, n_bad = 0, cycles = 0;
  bit          done = 0;

  function automatic bit is_open(int s);
    for (int p = m_cmt; p < m_tail; p++) if (p % D == s) return 1;
    return 0;
  endfunction

  function automatic bit exp_alloc_ready();
    return (m_tail - m_head < D) && !abort_i;
  endfunction

  function automatic bit exp_commit_ready();
    return !abort_i && (m_cmt < m_tail) && m_aok[m_cmt % D] && m_dok[m_cmt % D];
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_head = 0; m_cmt = 0; m_tail = 0;
      for (int i = 0; i < D; i++) begin
        m_aok[i] = 0; m_dok[i] = 0; m_addr[i] = '0; m_data[i] = '0;
      end
    end else begin
      bit a_acc, c_acc, d_acc, sa, sd;
      a_acc = alloc_valid_i && exp_alloc_ready();
      c_acc = commit_valid_i && exp_commit_ready();
      d_acc = (m_head < m_cmt) && cache_wr_ready_i;
      sa = sta_valid_i && !abort_i && is_open(int'(sta_slot_i));
      sd = std_valid_i && !abort_i && is_open(int'(std_slot_i));
      if (sa) begin m_aok[sta_slot_i] = 1; m_addr[sta_slot_i] = sta_addr_i; end
      if (sd) begin m_dok[std_slot_i] = 1; m_data[std_slot_i] = std_data_i; end
      if (abort_i) m_tail = m_cmt;
      else if (a_acc) begin
        m_aok[m_tail % D] = 0; m_dok[m_tail % D] = 0; m_tail++;
      end
      if (c_acc) m_cmt++;
      if (d_acc) m_head++;
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_ni && !done) begin
      int cnt, sel;
      bit found;
      check("R1", "alloc_ready", 64'(alloc_ready_o), 64'(exp_alloc_ready()));
      check("R5/R9", "alloc_ptr", 64'(alloc_ptr_o), 64'(m_tail % P2));
      check("R2/R3", "commit_ready", 64'(commit_ready_o), 64'(exp_commit_ready()));
      check("R4", "wr_valid", 64'(cache_wr_valid_o), 64'(m_head < m_cmt));
      if (m_head < m_cmt) begin
        check("R4", "wr_addr", 64'(cache_wr_addr_o), 64'(m_addr[m_head % D]));
        check("R4", "wr_data", cache_wr_data_o, m_data[m_head % D]);
      end
      found = 0; sel = 0;
      cnt = (int'(ld_ptr_i) - (m_head % P2) + P2) % P2;
      for (int k = 0; k < cnt; k++) begin
        int s;
        s = (m_head + k) % D;
        if (m_head + k < m_tail && m_aok[s] && m_addr[s] == ld_addr_i) begin
          found = 1; sel = s;
        end
      end
      check("R6/R7", "ld_hit", 64'(ld_hit_o), 64'(ld_valid_i && found && m_dok[sel]));
      check("R8", "ld_wait", 64'(ld_wait_o), 64'(ld_valid_i && found && !m_dok[sel]));
      check("R6/R7", "ld_data", ld_data_o,
            (ld_valid_i && found && m_dok[sel]) ? m_data[sel] : 64'd0);
    end
  end

  task automatic idle();
    alloc_valid_i = 0; sta_valid_i = 0; std_valid_i = 0; commit_valid_i = 0;
    abort_i = 0; ld_valid_i = 0; cache_wr_ready_i = 0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=50000 cycles", cycles);
      finish_run();
    end
  end

  localparam logic [AW-1:0] A0 = 32'h0000_0100;

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R7 directed: three stores to one address
    step(); alloc_valid_i = 1;
    step(); alloc_valid_i = 1;
    step(); alloc_valid_i = 1;
    step(); sta_valid_i = 1; sta_slot_i = 0; sta_addr_i = A0;
            std_valid_i = 1; std_slot_i = 1; std_data_i = 64'h1111;
    step(); sta_valid_i = 1; sta_slot_i = 1; sta_addr_i = A0;
            std_valid_i = 1; std_slot_i = 0; std_data_i = 64'h0000_aaaa;
    step(); sta_valid_i = 1; sta_slot_i = 2; sta_addr_i = A0;
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 3;  // R8: youngest lacks data
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 2;  // R7: slot 1 wins
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 0;  // nothing older
    step(); std_valid_i = 1; std_slot_i = 2; std_data_i = 64'h2222;
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 3;
    // R2: write to unallocated slot ignored
    step(); sta_valid_i = 1; sta_slot_i = 5; sta_addr_i = A0;
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 3;
    // R5: commit one, then abort
    step(); commit_valid_i = 1;
    step(); abort_i = 1; alloc_valid_i = 1; commit_valid_i = 1;
    step(); ld_valid_i = 1; ld_addr_i = A0; ld_ptr_i = 1;
    step(); cache_wr_ready_i = 1;
    step();
    // random traffic with wraps, stalls and aborts
    for (int c = 0; c < 8000; c++) begin
      int occ, rdy_pct;
      step();
      occ = m_tail - m_head;
      rdy_pct = (c < 3000) ? 30 : 80;
      alloc_valid_i    = ($urandom % 100) < 60;
      commit_valid_i   = ($urandom % 100) < 50;
      cache_wr_ready_i = ($urandom % 100) < rdy_pct;
      abort_i          = ($urandom % 100) < 3;
      sta_valid_i = ($urandom % 100) < 60;
      sta_slot_i  = IW'((($urandom % 4) == 0) ? $urandom : (m_cmt + $urandom % D));
      sta_addr_i  = A0 + AW'(4 * ($urandom % 4));
      std_valid_i = ($urandom % 100) < 60;
      std_slot_i  = IW'((($urandom % 4) == 0) ? $urandom : (m_cmt + $urandom % D));
      std_data_i  = {$urandom, $urandom};
      ld_valid_i  = ($urandom % 100) < 70;
      ld_addr_i   = A0 + AW'(4 * ($urandom % 4));
      ld_ptr_i    = PW'((m_head + int'($urandom % (occ + 1))) % P2);
    end
    step();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule